// File: doc/BRIEF.md
# Five-Stage Scalar Pipeline Sequencer with Halt Control

This block sequences a five-stage in-order scalar pipeline: fetch, register read, execute, data fetch and writeback. It owns the 12-bit fetch PC, the four inter-stage latches (each holding a valid bit, PC, instruction word, decode flags and destination register), and the load-use interlock. The fetch PC drives an instruction memory read port, and the word returned in the same cycle is latched together with decode flags that an outside decoder derives from that word.

Halting is built into the sequencing. An instruction flagged as a stop (a break, or a status write that sets the halt bit) acts when it reaches writeback. It retires, the halt bit sets, and nothing else in the pipeline moves in that cycle. The younger work is then dropped, and the fetch PC is reloaded from the execute-side latch, so a later resume restarts at the instruction after the stop. A host can write the PC at any time, which empties every stage at once. A host can also freeze the pipeline and later release it with nothing lost. The ALU, data memory and vector unit sit outside the block. Execute-stage forwarding selects are provided for them.

Top module: `pipe_seq`

## Requirements
- R1: After reset the block is halted, imem_addr is 0, wb_valid is 0 and every stage is empty.
- R2: While running without a stall or flush, imem_addr advances by 4 each cycle, wrapping from 0xFFC to 0x000; bits [1:0] are always 0.
- R3: Instructions retire in program order on wb_valid, with wb_pc and wb_dest of the fetched word, one per cycle when no interlock applies; ex_iw is the word fetched at ex_pc.
- R4: The instruction in register read stalls for exactly one cycle (one bubble inserted, fetch held) when the instruction ahead of it is a load with nonzero destination equal to its rs field (iw[25:21]) while it uses rs, or to its rt field (iw[20:16]) while it uses rt; a zero destination or an unused field causes no stall.
- R5: ex_fwd_rs (ex_fwd_rt) is 1 exactly when execute and writeback both hold valid instructions and the writeback destination is nonzero and equals the execute rs (rt) field; register 0 is never forwarded.
- R6: When a stop-flagged instruction is at writeback while running, it retires that cycle, halted is 1 from the next cycle, and no other instruction retires until the block is resumed.
- R7: After a stop at PC p, imem_addr is (p+4) mod 4096 while halted, and after resume the next instruction to retire is at (p+4) mod 4096.
- R8: host_pc_we takes effect in the cycle it is asserted: nothing retires in that cycle, the next imem_addr is host_pc_data with bits [1:0] cleared, and the first retirement after it is at that address; the halted state is unchanged by it.
- R9: halt_set suppresses retirement in its cycle and makes halted 1; halt_clr while halted (halt_set low) makes halted 0; while halted no instruction retires and a frozen pipeline resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 12 | Instruction memory byte address (fetch PC) |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dec_load | input | 1 | Fetched word is a load |
| dec_use_rs | input | 1 | Fetched word reads its rs field |
| dec_use_rt | input | 1 | Fetched word reads its rt field |
| dec_stop | input | 1 | Fetched word halts the block at writeback |
| dec_dest | input | 5 | Destination register of the fetched word |
| host_pc_we | input | 1 | Host PC write strobe |
| host_pc_data | input | 12 | Host PC value |
| halt_set | input | 1 | Host halt request |
| halt_clr | input | 1 | Host resume request |
| halted | output | 1 | Pipeline halted |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| ex_pc | output | 12 | PC of the execute-stage instruction |
| ex_iw | output | 32 | Word of the execute-stage instruction |
| ex_fwd_rs | output | 1 | Forward writeback result to rs operand |
| ex_fwd_rt | output | 1 | Forward writeback result to rt operand |
| wb_valid | output | 1 | An instruction retires this cycle |
| wb_pc | output | 12 | PC of the writeback-stage instruction |
| wb_dest | output | 5 | Destination of the writeback-stage instruction |

## Verification
The checker watches on every cycle the PC step and alignment, the held fetch PC during an interlock, the PC load and empty writeback after a host write, the halt that follows a stop at writeback, and the absence of register-0 forwarding and of retirement while halted. Only the bench scenarios can show that the retired PC stream follows program order across wrap, that each load-use pair costs exactly one cycle and other pairs none, and that resume after a stop lands on the following instruction. The bench checks these against a program held in the bench and a model of expected order and spacing.

// File: rtl/pipe_seq.sv
module pipe_seq #(
  parameter int PC_W = 12,
  parameter int IW_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] imem_addr,
  input  logic [IW_W-1:0] imem_data,
  input  logic            dec_load,
  input  logic            dec_use_rs,
  input  logic            dec_use_rt,
  input  logic            dec_stop,
  input  logic [4:0]      dec_dest,
  input  logic            host_pc_we,
  input  logic [PC_W-1:0] host_pc_data,
  input  logic            halt_set,
  input  logic            halt_clr,
  output logic            halted,
  output logic            ex_valid,
  output logic [PC_W-1:0] ex_pc,
  output logic [IW_W-1:0] ex_iw,
  output logic            ex_fwd_rs,
  output logic            ex_fwd_rt,
  output logic            wb_valid,
  output logic [PC_W-1:0] wb_pc,
  output logic [4:0]      wb_dest
);
  localparam logic [PC_W-1:0] STEP  = PC_W'(4);
  localparam logic [PC_W-1:0] ALIGN = ~PC_W'(3);

  typedef struct packed {
    logic            v;
    logic [PC_W-1:0] pc;
    logic [IW_W-1:0] iw;
    logic            ld;
    logic            urs;
    logic            urt;
    logic            stop;
    logic [4:0]      dst;
  } slot_t;

  function automatic slot_t bubble(input logic [PC_W-1:0] p);
    slot_t s;
    s    = '0;
    s.pc = p;
    return s;
  endfunction

  slot_t ifrd, rdex, exdf, dfwb;
  logic [PC_W-1:0] pc;

  wire [4:0] f_rs = ifrd.iw[25:21];
  wire [4:0] f_rt = ifrd.iw[20:16];
  wire [4:0] x_rs = rdex.iw[25:21];
  wire [4:0] x_rt = rdex.iw[20:16];

  wire run   = ~halted & ~halt_set & ~host_pc_we;
  wire brk   = dfwb.v & dfwb.stop;
  wire stall = rdex.v & rdex.ld & (rdex.dst != 5'd0) & ifrd.v &
               (((rdex.dst == f_rs) & ifrd.urs) | ((rdex.dst == f_rt) & ifrd.urt));
  wire fwd_ok = rdex.v & dfwb.v & (dfwb.dst != 5'd0);

  assign imem_addr = pc;
  assign ex_valid  = rdex.v;
  assign ex_pc     = rdex.pc;
  assign ex_iw     = rdex.iw;
  assign ex_fwd_rs = fwd_ok & (dfwb.dst == x_rs);
  assign ex_fwd_rt = fwd_ok & (dfwb.dst == x_rt);
  assign wb_valid  = run & dfwb.v;
  assign wb_pc     = dfwb.pc;
  assign wb_dest   = dfwb.dst;

  always_ff @(posedge clk) begin
    if (!rst_n)         halted <= 1'b1;
    else if (halt_set)  halted <= 1'b1;
    else if (halt_clr)  halted <= 1'b0;
    else if (run & brk) halted <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= '0;
      ifrd <= bubble('0);
      rdex <= bubble('0);
      exdf <= bubble('0);
      dfwb <= bubble('0);
    end else if (host_pc_we) begin
      pc   <= host_pc_data & ALIGN;
      ifrd <= bubble(host_pc_data & ALIGN);
      rdex <= bubble(host_pc_data & ALIGN);
      exdf <= bubble(host_pc_data & ALIGN);
      dfwb <= bubble(host_pc_data & ALIGN);
    end else if (run & brk) begin
      pc   <= exdf.pc;
      ifrd <= bubble(exdf.pc);
      rdex <= bubble(exdf.pc);
      exdf <= bubble(exdf.pc);
      dfwb <= bubble(exdf.pc);
    end else if (run) begin
      dfwb <= exdf;
      exdf <= rdex;
      if (stall) begin
        rdex <= bubble(ifrd.pc);
      end else begin
        rdex <= ifrd;
        ifrd <= '{v: 1'b1, pc: pc, iw: imem_data, ld: dec_load, urs: dec_use_rs,
                  urt: dec_use_rt, stop: dec_stop, dst: dec_dest};
        pc   <= pc + STEP;
      end
    end
  end
endmodule

module pipe_seq_chk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] imem_addr,
  input logic            host_pc_we,
  input logic [PC_W-1:0] host_pc_data,
  input logic            halt_set,
  input logic            halted,
  input logic            wb_valid,
  input logic [4:0]      wb_dest,
  input logic            ex_fwd_rs,
  input logic            ex_fwd_rt,
  input logic            stall,
  input logic            brk
);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_set && !host_pc_we && !stall && !brk) |=>
      imem_addr == $past(imem_addr) + PC_W'(4));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !host_pc_we && !brk) |=> $stable(imem_addr));

  // R8
  pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_pc_we |=> (imem_addr == ($past(host_pc_data) & ~PC_W'(3))) && !wb_valid);

  // R6
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !halted && !halt_set && !host_pc_we) |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !wb_valid);

  // R5
  no_r0_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_rs || ex_fwd_rt) |-> wb_dest != 5'd0);
endmodule

bind pipe_seq pipe_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .host_pc_we(host_pc_we),
  .host_pc_data(host_pc_data), .halt_set(halt_set), .halted(halted),
  .wb_valid(wb_valid), .wb_dest(wb_dest), .ex_fwd_rs(ex_fwd_rs),
  .ex_fwd_rt(ex_fwd_rt), .stall(stall), .brk(brk)
);

// File: tb/test_pipe_seq.sv
module test_pipe_seq;
  localparam int PC_W  = 12;
  localparam int WORDS = 2 ** (PC_W - 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] imem_addr, host_pc_data = '0, ex_pc, wb_pc;
  logic [31:0] imem_data, ex_iw;
  logic dec_load, dec_use_rs, dec_use_rt, dec_stop;
  logic [4:0] dec_dest, wb_dest;
  logic host_pc_we = 0, halt_set = 0, halt_clr = 0;
  logic halted, ex_valid, ex_fwd_rs, ex_fwd_rt, wb_valid;

  always #2.5 clk = ~clk;

  logic [31:0] mem [WORDS];
  bit ld [WORDS], urs [WORDS], urt [WORDS], stp [WORDS];
  logic [4:0] dst [WORDS];

  always_comb begin
    imem_data  = mem[imem_addr[PC_W-1:2]];
    dec_load   = ld[imem_addr[PC_W-1:2]];
    dec_use_rs = urs[imem_addr[PC_W-1:2]];
    dec_use_rt = urt[imem_addr[PC_W-1:2]];
    dec_stop   = stp[imem_addr[PC_W-1:2]];
    dec_dest   = dst[imem_addr[PC_W-1:2]];
  end

  pipe_seq i_pipe_seq (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [PC_W-1:0] exp_pc = '0;
  bit exp_halted = 1, have_prev = 0, disturbed = 1;
  int prev_idx = 0, gap = 0;
  bit pend_addr = 0;
  logic [PC_W-1:0] pend_addr_val;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit haz(input int p, input int c);
    logic [4:0] rs, rt;
    rs = mem[c][25:21];
    rt = mem[c][20:16];
    return ld[p] && dst[p] != 0 && ((dst[p] == rs && urs[c]) || (dst[p] == rt && urt[c]));
  endfunction

  task automatic step(input bit pcw, input logic [PC_W-1:0] pcv, input bit hs, input bit hc);
    int idx;
    bit retire_stop;
    @(negedge clk);
    host_pc_we = pcw; host_pc_data = pcv; halt_set = hs; halt_clr = hc;
    #1;
    retire_stop = 0;
    chk(halted == exp_halted, "R6/R9 halted", halted, exp_halted);
    if (pend_addr) chk(imem_addr == pend_addr_val, "R7/R8 imem_addr", imem_addr, pend_addr_val);
    pend_addr = 0;
    if (pcw || hs || halted) chk(!wb_valid, "R8/R9 no retire", wb_valid, 0);
    if (wb_valid) begin
      idx = int'(wb_pc[PC_W-1:2]);
      chk(wb_pc == exp_pc, "R3 wb_pc order", wb_pc, exp_pc);
      chk(wb_dest == dst[idx], "R3 wb_dest", wb_dest, dst[idx]);
      if (have_prev && !disturbed)
        chk(gap + 1 == 1 + int'(haz(prev_idx, idx)), haz(prev_idx, idx) ? "R4 stall gap" : "R3 gap",
            gap + 1, 1 + int'(haz(prev_idx, idx)));
      exp_pc = wb_pc + PC_W'(4);
      prev_idx = idx; have_prev = 1; disturbed = 0; gap = 0;
      if (stp[idx]) begin
        retire_stop = 1; have_prev = 0;
        pend_addr = 1; pend_addr_val = exp_pc;
      end
    end else gap++;
    if (!pcw && !hs && !halted) begin
      logic [4:0] ers, ert;
      ers = ex_iw[25:21]; ert = ex_iw[20:16];
      if (ex_valid) chk(ex_iw == mem[ex_pc[PC_W-1:2]], "R3 ex_iw", ex_iw, mem[ex_pc[PC_W-1:2]]);
      chk(ex_fwd_rs == (ex_valid && wb_valid && wb_dest != 0 && wb_dest == ers),
          "R5 fwd_rs", ex_fwd_rs, ex_valid && wb_valid && wb_dest != 0 && wb_dest == ers);
      chk(ex_fwd_rt == (ex_valid && wb_valid && wb_dest != 0 && wb_dest == ert),
          "R5 fwd_rt", ex_fwd_rt, ex_valid && wb_valid && wb_dest != 0 && wb_dest == ert);
    end
    if (pcw) begin
      exp_pc = pcv & ~PC_W'(3); have_prev = 0; disturbed = 1;
      pend_addr = 1; pend_addr_val = pcv & ~PC_W'(3);
    end
    if (hs || hc || halted) disturbed = 1;
    if (hs) exp_halted = 1;
    else if (hc) exp_halted = 0;
    else if (retire_stop) exp_halted = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int wait_n;
    void'($urandom(32'd20211217));
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = {6'd0, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 16'($urandom)};
      ld[i]  = ($urandom_range(0, 3) == 0);
      urs[i] = $urandom_range(0, 1);
      urt[i] = $urandom_range(0, 1);
      stp[i] = ($urandom_range(0, 49) == 0);
      dst[i] = 5'($urandom_range(0, 3));
    end
    for (int i = 64; i < 80; i++) begin
      mem[i] = '0; ld[i] = 0; urs[i] = 0; urt[i] = 0; stp[i] = 0; dst[i] = 5'd1;
    end
    ld[64] = 1; dst[64] = 5'd2; mem[65][25:21] = 5'd2; urs[65] = 1;
    ld[66] = 1; dst[66] = 5'd0; urs[67] = 1;
    ld[68] = 1; dst[68] = 5'd3; mem[69][20:16] = 5'd3; urt[69] = 0;
    ld[70] = 1; dst[70] = 5'd3; mem[71][20:16] = 5'd3; urt[71] = 1;
    stp[74] = 1;
    stp[WORDS-3] = 0; stp[WORDS-2] = 0; stp[WORDS-1] = 0; stp[0] = 0; stp[1] = 0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(halted == 1, "R1 halted", halted, 1);
    chk(imem_addr == 0, "R1 imem_addr", imem_addr, 0);
    chk(wb_valid == 0, "R1 wb_valid", wb_valid, 0);
    rst_n = 1;
    step(1, 12'h100, 0, 0);
    step(0, 0, 0, 1);
    repeat (25) step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    repeat (6) step(0, 0, 0, 0);
    step(1, 12'hFF8, 0, 0);
    repeat (10) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    repeat (2) step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    wait_n = 0;
    for (int c = 0; c < 4000; c++) begin
      if (halted) begin
        wait_n++;
        if (wait_n > 3) begin
          wait_n = 0;
          if ($urandom_range(0, 3) == 0) step(1, 12'($urandom), 0, 0);
          step(0, 0, 0, 1);
        end else step(0, 0, 0, 0);
      end else if ($urandom_range(0, 149) == 0) step(1, 12'($urandom), 0, 0);
      else if ($urandom_range(0, 149) == 0) step(0, 0, 1, 0);
      else step(0, 0, 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule